// File: doc/BRIEF.md
# Dual-Address Burst Read Initiator Sequencer

This block drives the master side of a PCI-style bus for burst reads to a 64-bit address over a 32-bit multiplexed address/data path. When the local side requests the bus and the grant arrives, it issues two address phases back to back. The first carries the low address word with the dual-address command. The second carries the high address word with the read command the local side supplies. A turnaround cycle follows, with the bus released and the byte enables driven. Data phases then run until the programmed number of words has been received.

On the local side, one address input is presented twice. The low word is given while the status reads "address load" for the first time. The high word is given during the first address phase, while the status still reads "address load". A per-cycle local ready input paces the initiator-ready line with a lag of one cycle, so the local side can insert wait states. Each completed word is handed over one cycle after its completion, with a one-cycle transfer strobe. A word counter, which is also visible at the ports, counts down to the end of the burst.

Top module: `dac_rd_init`

## Requirements
- R1: While reset is held, bus_frame_n, bus_irdy_n, bus_req_n and loc_xfer_n are high, bus_ad_oe is low and loc_status reads 0 (idle).
- R2: A low loc_req_n in idle pulls bus_req_n low on the next cycle, and loc_status reads 1 (waiting) until bus_gnt_n is seen low. The cycle after that, loc_status reads 2 (address load) with frame still high.
- R3: The first address phase follows the address-load cycle. In it bus_frame_n is low, bus_ad_oe is high, bus_ad_out holds the loc_adr_in value from the address-load cycle, bus_cbe_n[3:0] is 4'b1101 and loc_status still reads 2. loc_cnt shows the loc_blen value (1 or more) from the address-load cycle.
- R4: The second address phase follows the first. In it bus_ad_out holds the loc_adr_in value from the first phase, bus_cbe_n[3:0] holds the loc_cmd_in value from the first phase (4'b0110 for a memory read), and loc_status reads 3 (bus transaction) until the burst ends.
- R5: bus_req_n returns high on the cycle after any cycle in which bus_frame_n was low and loc_req_n was high. Otherwise it stays low.
- R6: From the turnaround cycle after the second address phase until the burst ends, bus_ad_oe is low and bus_cbe_n carries the loc_be_n value from the previous cycle.
- R7: While bus_frame_n is low in the data window, bus_irdy_n equals the loc_rdy_n value of the previous cycle.
- R8: A data phase completes on a cycle in which bus_irdy_n and bus_trdy_n are both low. On the next cycle loc_xfer_n is low for one cycle, loc_dat_out holds the bus_ad_in word of the completing cycle, and loc_cnt has dropped by one. A burst delivers exactly loc_blen strobes in bus order.
- R9: bus_frame_n rises only together with a low bus_irdy_n, and only when one word remains. bus_irdy_n then stays low until that word completes. On the next cycle bus_irdy_n and bus_frame_n are high and loc_status reads 0.
- R10: loc_gnt_n follows bus_gnt_n in the same cycle (default variant).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| loc_req_n | input | 1 | Local request for a bus transaction, active low |
| loc_gnt_n | output | 1 | Bus grant as seen by the local side |
| loc_adr_in | input | DW | Low, then high, address word |
| loc_cmd_in | input | 4 | Read command for the second address phase |
| loc_blen | input | CNTW | Burst length in words |
| loc_rdy_n | input | 1 | Local side ready to take data, active low |
| loc_be_n | input | DW/8 | Byte enables for the data phases, active low |
| loc_status | output | 4 | Sequencer status code |
| loc_cnt | output | CNTW | Words still to be delivered |
| loc_dat_out | output | DW | Delivered read word |
| loc_xfer_n | output | 1 | One-cycle strobe marking a valid loc_dat_out, active low |
| bus_req_n | output | 1 | Bus request, active low |
| bus_gnt_n | input | 1 | Bus grant, active low |
| bus_frame_n | output | 1 | Frame, active low |
| bus_irdy_n | output | 1 | Initiator ready, active low |
| bus_trdy_n | input | 1 | Target ready, active low |
| bus_ad_in | input | DW | Address/data bus, incoming |
| bus_ad_out | output | DW | Address/data bus, outgoing |
| bus_ad_oe | output | 1 | Output enable of bus_ad_out |
| bus_cbe_n | output | DW/8 | Command / byte-enable lines |

## Verification
Two decisions can fall in one cycle. The hand-over of a completed word lowers the counter, and the end-of-burst decision reads that same lowered count to release frame. The bench provokes this coincidence with random target wait states and random local-ready stalls around the next-to-last word, and also with a one-word burst, where frame must rise as early as the turnaround cycle. Each case is judged by checking, cycle by cycle, that frame rises only while initiator ready is low and exactly one word remains, and that the count of strobes equals the burst length.

// File: rtl/dac_pkg.sv
package dac_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_LOAD,
      ST_ADR1,
      ST_ADR2,
      ST_XFER
   } seq_st_e;

   localparam logic [3:0] STS_IDLE  = 4'h0;
   localparam logic [3:0] STS_WAIT  = 4'h1;
   localparam logic [3:0] STS_LOAD  = 4'h2;
   localparam logic [3:0] STS_BUSX  = 4'h3;

   localparam logic [3:0] CMD_DUAL  = 4'b1101;
   localparam logic [3:0] CMD_MEMRD = 4'b0110;

endpackage

// File: rtl/dac_seq_fsm.sv
module dac_seq_fsm
   import dac_pkg::*;
#(
   parameter int CNTW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            loc_req_n,
   input  logic            loc_rdy_n,
   input  logic [CNTW-1:0] loc_blen,
   input  logic            bus_gnt_n,
   input  logic            bus_trdy_n,
   output seq_st_e         st,
   output seq_st_e         st_nx,
   output logic            done,
   output logic [CNTW-1:0] cnt,
   output logic [3:0]      status,
   output logic            bus_req_n,
   output logic            bus_frame_n,
   output logic            bus_irdy_n
);

   localparam logic [CNTW-1:0] ONE = CNTW'(1);

   seq_st_e         st_q;
   logic            frame_q, irdy_q, req_q;
   logic            frame_nx, irdy_nx, req_nx;
   logic [CNTW-1:0] cnt_q, cnt_nx;

   assign done = (st_q == ST_XFER) && !irdy_q && !bus_trdy_n;

   always_comb begin
      st_nx    = st_q;
      frame_nx = frame_q;
      irdy_nx  = irdy_q;
      cnt_nx   = done ? cnt_q - ONE : cnt_q;
      case (st_q)
         ST_IDLE: if (!loc_req_n) st_nx = ST_WAIT;
         ST_WAIT: if (!bus_gnt_n) st_nx = ST_LOAD;
         ST_LOAD: begin
            st_nx    = ST_ADR1;
            frame_nx = 1'b0;
            cnt_nx   = loc_blen;
         end
         ST_ADR1: st_nx = ST_ADR2;
         ST_ADR2: begin
            st_nx    = ST_XFER;
            irdy_nx  = loc_rdy_n;
            frame_nx = (cnt_q == ONE) && !loc_rdy_n;
         end
         ST_XFER: begin
            if (done && cnt_q == ONE) begin
               st_nx    = ST_IDLE;
               frame_nx = 1'b1;
               irdy_nx  = 1'b1;
            end else begin
               irdy_nx  = frame_q ? 1'b0 : loc_rdy_n;
               frame_nx = frame_q | ((cnt_nx == ONE) && !irdy_nx);
            end
         end
         default: st_nx = ST_IDLE;
      endcase
   end

   always_comb begin
      req_nx = req_q;
      if (st_q == ST_IDLE && !loc_req_n) req_nx = 1'b0;
      if (!frame_q && loc_req_n)         req_nx = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         frame_q <= 1'b1;
         irdy_q  <= 1'b1;
         req_q   <= 1'b1;
         cnt_q   <= '0;
      end else begin
         st_q    <= st_nx;
         frame_q <= frame_nx;
         irdy_q  <= irdy_nx;
         req_q   <= req_nx;
         cnt_q   <= cnt_nx;
      end
   end

   always_comb begin
      case (st_q)
         ST_WAIT:          status = STS_WAIT;
         ST_LOAD, ST_ADR1: status = STS_LOAD;
         ST_ADR2, ST_XFER: status = STS_BUSX;
         default:          status = STS_IDLE;
      endcase
   end

   assign st          = st_q;
   assign cnt         = cnt_q;
   assign bus_req_n   = req_q;
   assign bus_frame_n = frame_q;
   assign bus_irdy_n  = irdy_q;

   // R7
   irdy_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_irdy_n && !bus_frame_n) |-> $past(!loc_rdy_n));

   // R9
   frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_frame_n) && (st_q == ST_XFER) |-> (!bus_irdy_n && cnt_q == ONE));

   // R2
   load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_frame_n) |-> (status == STS_LOAD && $past(status == STS_LOAD)));

   // R3
   blen_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ADR1) |-> (cnt_q != '0));

endmodule

// File: rtl/dac_addr_path.sv
module dac_addr_path
   import dac_pkg::*;
#(
   parameter int DW  = 32,
   parameter int CBW = DW / 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  seq_st_e        st_nx,
   input  logic [DW-1:0]  loc_adr_in,
   input  logic [3:0]     loc_cmd_in,
   input  logic [CBW-1:0] loc_be_n,
   output logic [DW-1:0]  bus_ad_out,
   output logic           bus_ad_oe,
   output logic [CBW-1:0] bus_cbe_n
);

   logic [CBW-1:0] dual_w, rdcmd_w;

   generate
      if (CBW == 4) begin : g_narrow
         assign dual_w  = CMD_DUAL;
         assign rdcmd_w = loc_cmd_in;
      end else begin : g_wide
         assign dual_w  = {{(CBW-4){1'b1}}, CMD_DUAL};
         assign rdcmd_w = {{(CBW-4){1'b1}}, loc_cmd_in};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_ad_out <= '0;
         bus_ad_oe  <= 1'b0;
         bus_cbe_n  <= '1;
      end else begin
         case (st_nx)
            ST_ADR1: begin
               bus_ad_out <= loc_adr_in;
               bus_ad_oe  <= 1'b1;
               bus_cbe_n  <= dual_w;
            end
            ST_ADR2: begin
               bus_ad_out <= loc_adr_in;
               bus_ad_oe  <= 1'b1;
               bus_cbe_n  <= rdcmd_w;
            end
            ST_XFER: begin
               bus_ad_oe  <= 1'b0;
               bus_cbe_n  <= loc_be_n;
            end
            default: begin
               bus_ad_oe  <= 1'b0;
               bus_cbe_n  <= '1;
            end
         endcase
      end
   end

endmodule

// File: rtl/dac_rd_capture.sv
module dac_rd_capture #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          done,
   input  logic [DW-1:0] bus_ad_in,
   output logic [DW-1:0] loc_dat_out,
   output logic          loc_xfer_n
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loc_dat_out <= '0;
         loc_xfer_n  <= 1'b1;
      end else begin
         loc_xfer_n <= !done;
         if (done) loc_dat_out <= bus_ad_in;
      end
   end

endmodule

// File: rtl/dac_rd_init.sv
module dac_rd_init
   import dac_pkg::*;
#(
   parameter int DW      = 32,
   parameter int CNTW    = 8,
   parameter bit GNT_REG = 1'b0,
   localparam int CBW    = DW / 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            loc_req_n,
   output logic            loc_gnt_n,
   input  logic [DW-1:0]   loc_adr_in,
   input  logic [3:0]      loc_cmd_in,
   input  logic [CNTW-1:0] loc_blen,
   input  logic            loc_rdy_n,
   input  logic [CBW-1:0]  loc_be_n,
   output logic [3:0]      loc_status,
   output logic [CNTW-1:0] loc_cnt,
   output logic [DW-1:0]   loc_dat_out,
   output logic            loc_xfer_n,
   output logic            bus_req_n,
   input  logic            bus_gnt_n,
   output logic            bus_frame_n,
   output logic            bus_irdy_n,
   input  logic            bus_trdy_n,
   input  logic [DW-1:0]   bus_ad_in,
   output logic [DW-1:0]   bus_ad_out,
   output logic            bus_ad_oe,
   output logic [CBW-1:0]  bus_cbe_n
);

   generate
      if (DW % 8 != 0 || CBW < 4) begin : g_bad_dw
         $error("DW must be a multiple of 8 and at least 32");
      end
      if (CNTW < 1) begin : g_bad_cntw
         $error("CNTW must be at least 1");
      end
   endgenerate

   seq_st_e st, st_nx;
   logic    done;

   dac_seq_fsm #(.CNTW(CNTW)) u_fsm (
      .clk(clk), .rst_n(rst_n), .loc_req_n(loc_req_n), .loc_rdy_n(loc_rdy_n),
      .loc_blen(loc_blen), .bus_gnt_n(bus_gnt_n), .bus_trdy_n(bus_trdy_n),
      .st(st), .st_nx(st_nx), .done(done), .cnt(loc_cnt), .status(loc_status),
      .bus_req_n(bus_req_n), .bus_frame_n(bus_frame_n), .bus_irdy_n(bus_irdy_n)
   );

   dac_addr_path #(.DW(DW), .CBW(CBW)) u_adr (
      .clk(clk), .rst_n(rst_n), .st_nx(st_nx), .loc_adr_in(loc_adr_in),
      .loc_cmd_in(loc_cmd_in), .loc_be_n(loc_be_n), .bus_ad_out(bus_ad_out),
      .bus_ad_oe(bus_ad_oe), .bus_cbe_n(bus_cbe_n)
   );

   dac_rd_capture #(.DW(DW)) u_cap (
      .clk(clk), .rst_n(rst_n), .done(done), .bus_ad_in(bus_ad_in),
      .loc_dat_out(loc_dat_out), .loc_xfer_n(loc_xfer_n)
   );

   generate
      if (GNT_REG) begin : g_gnt_reg
         logic gnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) gnt_q <= 1'b1;
            else        gnt_q <= bus_gnt_n;
         end
         assign loc_gnt_n = gnt_q;
      end else begin : g_gnt_wire
         assign loc_gnt_n = bus_gnt_n;
      end
   endgenerate

   // R8
   cmpl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!loc_xfer_n && loc_dat_out == $past(bus_ad_in)));

   // R3
   dual_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_frame_n) |-> (bus_ad_oe && bus_cbe_n[3:0] == CMD_DUAL));

   // R4
   second_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_frame_n) |=> (bus_ad_oe && bus_cbe_n[3:0] == $past(loc_cmd_in)));

   // R6
   turn_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_XFER) |-> !bus_ad_oe);

endmodule

// File: tb/sim_dac_rd_init.sv
`timescale 1ns/1ps
module sim_dac_rd_init;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        loc_req_n = 1'b1;
   logic        loc_gnt_n;
   logic [31:0] loc_adr_in = '0;
   logic [3:0]  loc_cmd_in = 4'b0110;
   logic [7:0]  loc_blen = 8'd1;
   logic        loc_rdy_n = 1'b1;
   logic [3:0]  loc_be_n = 4'hF;
   logic [3:0]  loc_status;
   logic [7:0]  loc_cnt;
   logic [31:0] loc_dat_out;
   logic        loc_xfer_n;
   logic        bus_req_n;
   logic        bus_gnt_n = 1'b1;
   logic        bus_frame_n;
   logic        bus_irdy_n;
   logic        bus_trdy_n = 1'b1;
   logic [31:0] bus_ad_in = '0;
   logic [31:0] bus_ad_out;
   logic        bus_ad_oe;
   logic [3:0]  bus_cbe_n;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #2.5 clk = ~clk;

   dac_rd_init u0 (.*);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run did not finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic logic rnd();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr[0] & lfsr[3];
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(bus_frame_n && bus_irdy_n && bus_req_n && loc_xfer_n, "R1 controls high",
          {bus_frame_n, bus_irdy_n, bus_req_n, loc_xfer_n}, 32'hF);
      chk(!bus_ad_oe, "R1 oe low", bus_ad_oe, 0);
      chk(loc_status == 4'h0, "R1 status idle", loc_status, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(loc_status == 4'h0, "R1 idle after release", loc_status, 0);
   endtask

   task automatic t_burst(input logic [31:0] lo, input logic [31:0] hi, input int blen,
                          input logic [3:0] be, input bit rdy_rand, input bit trdy_rand,
                          input bit hold_req);
      int dn = 0, strb = 0, k = 0;
      logic pend = 1'b0;
      logic [31:0] pend_dat = '0;
      logic prev_rdy;
      logic [31:0] word;
      bit fin = 0;
      @(negedge clk);
      loc_req_n = 1'b0; bus_gnt_n = 1'b1;
      @(negedge clk);
      chk(bus_req_n == 1'b0, "R2 request", bus_req_n, 0);
      chk(loc_status == 4'h1, "R2 wait status", loc_status, 1);
      chk(loc_gnt_n == bus_gnt_n, "R10 grant high", loc_gnt_n, bus_gnt_n);
      bus_gnt_n = 1'b0;
      #1 chk(loc_gnt_n == 1'b0, "R10 grant low", loc_gnt_n, 0);
      @(negedge clk);
      chk(loc_status == 4'h2 && bus_frame_n, "R2 load status", {bus_frame_n, loc_status}, 32'h12);
      loc_adr_in = lo; loc_blen = 8'(blen);
      if (!hold_req) loc_req_n = 1'b1;
      @(negedge clk);
      chk(!bus_frame_n && bus_ad_oe, "R3 frame/oe", {bus_frame_n, bus_ad_oe}, 1);
      chk(bus_ad_out == lo, "R3 low addr", bus_ad_out, lo);
      chk(bus_cbe_n == 4'b1101, "R3 dual cmd", bus_cbe_n, 4'b1101);
      chk(loc_status == 4'h2, "R3 status held", loc_status, 2);
      chk(loc_cnt == 8'(blen), "R3 count loaded", loc_cnt, blen);
      chk(bus_req_n == 1'b0, "R5 req still low", bus_req_n, 0);
      loc_adr_in = hi; loc_cmd_in = 4'b0110; loc_be_n = be;
      loc_rdy_n = rdy_rand ? rnd() : 1'b0;
      prev_rdy = loc_rdy_n;
      @(negedge clk);
      chk(bus_ad_out == hi && bus_ad_oe, "R4 high addr", bus_ad_out, hi);
      chk(bus_cbe_n == 4'b0110, "R4 read cmd", bus_cbe_n, 4'b0110);
      chk(loc_status == 4'h3, "R4 status", loc_status, 3);
      chk(bus_req_n == hold_req ? 1'b0 : 1'b1, "R5 release", bus_req_n, !hold_req);
      bus_gnt_n = 1'b1;
      if (hold_req) loc_req_n = 1'b1;
      while (!fin && k < 300) begin
         @(negedge clk);
         if (pend) begin
            chk(!loc_xfer_n && loc_dat_out == pend_dat, "R8 strobe/data", loc_dat_out, pend_dat);
            strb++;
         end else
            chk(loc_xfer_n, "R8 no strobe", loc_xfer_n, 1);
         chk(loc_cnt == 8'(blen - dn), "R8 count", loc_cnt, blen - dn);
         if (hold_req && k == 1)
            chk(bus_req_n, "R5 late release", bus_req_n, 1);
         if (dn == blen) begin
            chk(bus_irdy_n && bus_frame_n && loc_status == 4'h0, "R9 end idle",
                {bus_irdy_n, bus_frame_n, loc_status}, 32'h30);
            fin = 1;
         end else begin
            chk(!bus_ad_oe && bus_cbe_n == be, "R6 turn/be", {bus_ad_oe, bus_cbe_n}, be);
            if (!bus_frame_n)
               chk(bus_irdy_n == prev_rdy, "R7 irdy pacing", bus_irdy_n, prev_rdy);
            else
               chk(!bus_irdy_n && dn == blen - 1, "R9 last phase", {bus_irdy_n, 8'(dn)},
                   blen - 1);
            word = 32'hD000_0000 ^ (lo << 4) ^ 32'(dn * 32'h0101_0101);
            bus_trdy_n = (k == 0) ? 1'b1 : (trdy_rand ? rnd() : 1'b0);
            bus_ad_in  = bus_trdy_n ? 32'hDEAD_BEEF : word;
            pend = !bus_irdy_n && !bus_trdy_n;
            pend_dat = word;
            if (pend) dn++;
            loc_rdy_n = rdy_rand ? rnd() : 1'b0;
            prev_rdy = loc_rdy_n;
         end
         k++;
      end
      chk(strb == blen, "R8 strobe count", strb, blen);
      bus_trdy_n = 1'b1; loc_rdy_n = 1'b1;
      @(negedge clk);
      chk(bus_req_n && bus_frame_n && loc_xfer_n, "R9 bus released",
          {bus_req_n, bus_frame_n, loc_xfer_n}, 32'h7);
   endtask

   initial begin
      t_reset();
      t_burst(32'h1000_0040, 32'h0000_0007, 4, 4'h0, 0, 0, 0);
      t_burst(32'h2222_0100, 32'h0000_00A5, 6, 4'h3, 0, 1, 0);
      t_burst(32'h3333_0200, 32'h0000_0011, 5, 4'h0, 1, 0, 0);
      t_burst(32'h4444_0300, 32'h0000_0022, 8, 4'hC, 1, 1, 0);
      t_burst(32'h5555_0400, 32'h0000_0033, 1, 4'h0, 0, 0, 0);
      t_burst(32'h6666_0500, 32'h0000_0044, 1, 4'h5, 1, 1, 0);
      t_burst(32'h7777_0600, 32'h0000_0055, 3, 4'h0, 0, 1, 1);
      t_burst(32'h8888_0700, 32'h0000_0066, 2, 4'hA, 1, 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule